// File: doc/BRIEF.md
# Monotonic-Switching SAR Conversion Controller

This block sequences a 10-bit differential successive-approximation conversion whose capacitor array is switched monotonically. It is used beside an external comparator and two capacitor arrays, one per side. While the sample input is high, both arrays stay at their reset level and the comparator stays idle. When sample falls, the first comparison is requested at once, with no capacitor moved. Each later decision grounds exactly one capacitor of the current bit, on the side that won. The other side is left alone.

The comparator's self-timed loop is modelled on a system clock. A compare request goes out, and a decision counts as valid when either comparator output is high. Valid drops the request, which resets the comparator, and a programmable settling wait then runs before the next request. A thermometer token register, advanced by each valid, picks the bit flop that captures the decision. Those flops drive the switch controls directly. The four most significant bits also produce a stabilizer control: the OR of that bit's two side controls. A watchdog ends a conversion whose comparator never answers.

Top module: `sar_ms_ctrl`

## Requirements
- R1: After reset these outputs are all low: cmp_req_o, done_o, err_o, code_o, every switch control and every stabilizer control. cmp_rst_o is high.
- R2: While sample_i is high, from the next clock edge onward, all switch controls read 0 (0 = plate on the high reference, 1 = plate grounded), cmp_req_o is low, cmp_rst_o is high and err_o is low.
- R3: cmp_req_o rises in the cycle after sample_i is seen low, and every switch control is still 0 during that first request.
- R4: Decision k (k = 0 first) belongs to bit index 9-k. A valid decision with cmp_p_i high sets sw_p_o[9-k]; otherwise it sets sw_n_o[9-k]. The change shows in the cycle after valid. No other control changes, and a control never returns to 0 except through sampling.
- R5: After each of the first nine valid decisions, cmp_req_o, and with it the comparator reset cmp_rst_o = !cmp_req_o, stays low for exactly settle_i + 1 cycles. Then the next request rises.
- R6: code_o bit 9-k is 1 when cmp_p_i won decision k. Once the tenth decision is stored, code_o (equal to sw_p_o) and a one-cycle done_o pulse appear one cycle later.
- R7: cms_o[j] (j = 0..3) is the OR of sw_p_o[9-j] and sw_n_o[9-j], so it rises in the same cycle as that bit's switch control.
- R8: The comparator outputs have no effect while cmp_req_o is low.
- R9: If cmp_req_o stays high for timeout_i + 1 cycles without a valid decision, the conversion ends. The missing bit and all later bits read 0, err_o rises, and code_o and done_o follow one cycle later. err_o clears when sampling starts again.
- R10: Raising sample_i during a conversion abandons it. No done_o pulse is produced, and all switch controls return to 0.
- R11: If both comparator outputs are high together, the positive side wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | High: track input and hold arrays in reset; falling starts conversion |
| settle_i | input | 4 | Extra settling cycles after each decision |
| timeout_i | input | 8 | Watchdog limit for an unanswered request |
| cmp_p_i | input | 1 | Comparator positive-side decision |
| cmp_n_i | input | 1 | Comparator negative-side decision |
| cmp_req_o | output | 1 | Compare strobe |
| cmp_rst_o | output | 1 | Comparator reset |
| sw_p_o | output | 10 | Positive-side switch controls (1 = grounded) |
| sw_n_o | output | 10 | Negative-side switch controls (1 = grounded) |
| cms_o | output | 4 | Common-mode stabilizer controls, index 0 = MSB |
| code_o | output | 10 | Conversion result |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Conversion ended by the watchdog |

## Verification
A token pointing at the wrong stage shows at the switch ports in the cycle right after the decision: a wrong index gets set, or the one-bit-per-step rule breaks. A wrong state or settling count shows as a request gap that differs from settle_i + 1 at the very next request. A miscount of the ten decisions shows up as done_o arriving early or late, or as a code word that differs from the responses the comparator gave. Stale capture into the flops is visible as a switch change while no valid was present.

// File: rtl/sar_ms_ctrl.sv
module sar_ms_ctrl #(
  parameter int N    = 10,
  parameter int NCMS = 4,
  parameter int SW   = 4,
  parameter int TW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_i,
  input  logic [SW-1:0]   settle_i,
  input  logic [TW-1:0]   timeout_i,
  input  logic            cmp_p_i,
  input  logic            cmp_n_i,
  output logic            cmp_req_o,
  output logic            cmp_rst_o,
  output logic [N-1:0]    sw_p_o,
  output logic [N-1:0]    sw_n_o,
  output logic [NCMS-1:0] cms_o,
  output logic [N-1:0]    code_o,
  output logic            done_o,
  output logic            err_o
);

  typedef enum logic [2:0] {S_IDLE, S_TRACK, S_ASK, S_WAIT, S_END} st_t;

  st_t           st;
  logic [N-1:0]  tok;
  logic [N-1:0]  pick;
  logic [SW-1:0] cnt;
  logic [TW-1:0] wd;
  logic          vld, take;

  assign vld       = cmp_p_i | cmp_n_i;
  assign cmp_req_o = (st == S_ASK);
  assign cmp_rst_o = ~cmp_req_o;
  assign take      = cmp_req_o & vld & ~sample_i;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_bit
      if (k == 0) begin : g_first
        assign pick[N-1] = ~tok[0];
      end else begin : g_next
        assign pick[N-1-k] = tok[k-1] & ~tok[k];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sw_p_o[N-1-k] <= 1'b0;
          sw_n_o[N-1-k] <= 1'b0;
        end else if (sample_i) begin
          sw_p_o[N-1-k] <= 1'b0;
          sw_n_o[N-1-k] <= 1'b0;
        end else if (take && pick[N-1-k]) begin
          if (cmp_p_i) sw_p_o[N-1-k] <= 1'b1;
          else         sw_n_o[N-1-k] <= 1'b1;
        end
      end
    end
    for (k = 0; k < NCMS; k++) begin : g_cms
      assign cms_o[k] = sw_p_o[N-1-k] | sw_n_o[N-1-k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tok    <= '0;
      cnt    <= '0;
      wd     <= '0;
      code_o <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (sample_i) begin
        st    <= S_TRACK;
        tok   <= '0;
        err_o <= 1'b0;
      end else begin
        case (st)
          S_TRACK: begin
            st <= S_ASK;
            wd <= '0;
          end
          S_ASK: begin
            if (vld) begin
              tok <= {tok[N-2:0], 1'b1};
              wd  <= '0;
              if (pick[0]) st <= S_END;
              else begin
                st  <= S_WAIT;
                cnt <= settle_i;
              end
            end else if (wd >= timeout_i) begin
              err_o <= 1'b1;
              st    <= S_END;
            end else begin
              wd <= wd + 1'b1;
            end
          end
          S_WAIT: begin
            if (cnt == '0) st <= S_ASK;
            else           cnt <= cnt - 1'b1;
          end
          S_END: begin
            code_o <= sw_p_o;
            done_o <= 1'b1;
            st     <= S_IDLE;
          end
          default: st <= st;
        endcase
      end
    end
  end

  assert_track_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> (sw_p_o == '0 && sw_n_o == '0 && !cmp_req_o && !err_o));

  assert_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> ((($past(sw_p_o) & ~sw_p_o) == '0) && (($past(sw_n_o) & ~sw_n_o) == '0)));

  assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> ($countones((sw_p_o | sw_n_o) ^ $past(sw_p_o | sw_n_o)) <= 1));

  assert_one_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_p_o & sw_n_o) == '0);

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_i && !(cmp_req_o && (cmp_p_i || cmp_n_i))) |=> ($stable(sw_p_o) && $stable(sw_n_o)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (code_o == $past(sw_p_o)));

endmodule

// File: tb/sar_ms_ctrl_tb_top.sv
module sar_ms_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_i = 1'b0;
  logic [3:0] settle_i = '0;
  logic [7:0] timeout_i = 8'd5;
  logic cmp_p_i = 1'b0, cmp_n_i = 1'b0;
  logic cmp_req_o, cmp_rst_o, done_o, err_o;
  logic [9:0] sw_p_o, sw_n_o, code_o;
  logic [3:0] cms_o;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [10:0] sb_q[$];
  bit prev_done = 0;

  always #2.5 clk = ~clk;

  sar_ms_ctrl dut_i (.clk(clk), .rst_n(rst_n), .sample_i(sample_i), .settle_i(settle_i),
    .timeout_i(timeout_i), .cmp_p_i(cmp_p_i), .cmp_n_i(cmp_n_i), .cmp_req_o(cmp_req_o),
    .cmp_rst_o(cmp_rst_o), .sw_p_o(sw_p_o), .sw_n_o(sw_n_o), .cms_o(cms_o),
    .code_o(code_o), .done_o(done_o), .err_o(err_o));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: pops expected results when done_o appears (R6, R9, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        if (prev_done) chk(0, "R6 done longer than one cycle", 1, 0);
        if (sb_q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          logic [10:0] e;
          e = sb_q.pop_front();
          chk({err_o, code_o} == e, "R6/R9 result", {err_o, code_o}, e);
        end
      end
      prev_done = done_o;
    end
  end

  function automatic logic [3:0] cms_of(input logic [9:0] p, input logic [9:0] n);
    for (int j = 0; j < 4; j++) cms_of[j] = p[9-j] | n[9-j];
  endfunction

  task automatic convert(input logic [9:0] code, input int settle, input int dly,
                         input bit noisy, input bit both, input int stall);
    logic [9:0] ep, en, m;
    int lowc, hic;
    ep = '0; en = '0;
    settle_i = settle[3:0];
    @(negedge clk); sample_i = 1'b1;
    @(negedge clk);
    chk(sw_p_o == 0 && sw_n_o == 0 && !cmp_req_o && cmp_rst_o && !err_o, "R2 tracking",
        {sw_p_o, sw_n_o, cmp_req_o, err_o}, 0);
    if (stall < 0) sb_q.push_back({1'b0, code});
    else begin
      m = 10'h3FF << (10 - stall);
      sb_q.push_back({1'b1, code & m});
    end
    sample_i = 1'b0;
    @(negedge clk);
    chk(cmp_req_o && sw_p_o == 0 && sw_n_o == 0, "R3 first request", {cmp_req_o, sw_p_o}, 11'h400);
    for (int k = 0; k < 10; k++) begin
      if (k == stall) begin
        hic = 0;
        while (cmp_req_o && hic < 300) begin hic++; @(negedge clk); end
        chk(hic == int'(timeout_i) + 1, "R9 watchdog length", hic, int'(timeout_i) + 1);
        break;
      end
      repeat (dly) begin
        chk(cmp_req_o, "R5 request held", cmp_req_o, 1);
        @(negedge clk);
      end
      if (code[9-k]) begin cmp_p_i = 1'b1; cmp_n_i = both; ep[9-k] = 1'b1; end
      else           begin cmp_p_i = 1'b0; cmp_n_i = 1'b1; en[9-k] = 1'b1; end
      @(negedge clk);
      cmp_p_i = 1'b0; cmp_n_i = 1'b0;
      chk(sw_p_o == ep && sw_n_o == en, both ? "R11/R4 switch" : "R4 switch",
          {sw_p_o, sw_n_o}, {ep, en});
      chk(cms_o == cms_of(ep, en), "R7 stabilizer", cms_o, cms_of(ep, en));
      if (k == 9) break;
      lowc = 0;
      while (!cmp_req_o && lowc < 40) begin
        if (noisy) begin cmp_p_i = 1'b1; cmp_n_i = 1'b1; end
        lowc++;
        @(negedge clk);
      end
      cmp_p_i = 1'b0; cmp_n_i = 1'b0;
      chk(lowc == settle + 1, "R5 settle gap", lowc, settle + 1);
      if (noisy) chk(sw_p_o == ep && sw_n_o == en, "R8 ignored outside request",
                     {sw_p_o, sw_n_o}, {ep, en});
    end
    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R6 done arrived", sb_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmp_req_o && cmp_rst_o && !done_o && !err_o && sw_p_o == 0 && sw_n_o == 0 &&
        cms_o == 0 && code_o == 0, "R1 reset state", {cmp_req_o, done_o, err_o, code_o}, 0);
    rst_n = 1'b1;
    convert(10'h2AA, 0, 0, 0, 0, -1);
    convert(10'h3FF, 3, 1, 1, 0, -1);
    convert(10'h000, 15, 0, 0, 0, -1);
    convert(10'h155, 2, 0, 0, 1, -1);
    convert(10'h200, 1, 2, 1, 0, -1);
    timeout_i = 8'd5;
    convert(10'h3C3, 0, 0, 0, 0, 4);
    chk(err_o, "R9 error flag", err_o, 1);
    // R10: abandon mid-conversion
    settle_i = '0;
    @(negedge clk); sample_i = 1'b1;
    @(negedge clk); sample_i = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      cmp_p_i = 1'b1;
      @(negedge clk); cmp_p_i = 1'b0;
      @(negedge clk);
    end
    chk(sw_p_o == 10'h380, "R10 partial progress", sw_p_o, 10'h380);
    sample_i = 1'b1;
    @(negedge clk);
    chk(sw_p_o == 0 && sw_n_o == 0 && !cmp_req_o, "R10 abandon resets", {sw_p_o, sw_n_o}, 0);
    repeat (20) @(negedge clk);
    chk(!done_o && sb_q.size() == 0, "R10 no done", done_o, 0);
    convert(10'h0F0, 0, 0, 0, 0, -1);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule